// File: doc/BRIEF.md
# Ethernet frame status and error classifier

This block sits beside a 64-bit packet stream and only watches it. The stream uses valid/ready handshaking, start- and end-of-packet markers, a 3-bit count of unused bytes on the closing beat, and a client error flag. The block measures each frame and reads its header. On the beat that closes the frame, it presents a 40-bit status word and a 7-bit error vector. A status-valid strobe qualifies both. The data stream passes by untouched. The block is meant to feed statistics counters or a drop decision in the cycle the frame ends.

A beat counts only when valid and ready are both high. The first byte of a frame travels in bits [63:56] of its first beat. The following bytes fill each beat from the most significant byte down. The lengths cover destination address through FCS, and the preamble is not counted.

The header is gathered from the first three beats. The classification is computed in the closing cycle from the stored header bytes merged with the current beat, so a frame of one or two beats is classified correctly.

A two-state machine tracks each frame:
- `S_IDLE` (outside a frame). An accepted SOP without EOP takes the *open* transition to `S_BODY`. An accepted SOP with EOP is the *single-beat* case and stays in `S_IDLE`. Any other beat is ignored.
- `S_BODY` (inside a frame). An accepted EOP takes the *close* transition back to `S_IDLE`. An accepted SOP without EOP takes the *restart* transition: the machine stays in `S_BODY` and clears everything gathered for the abandoned frame.

Top module: `frame_status_classifier`

## Requirements
- R1: `stat_valid` is high exactly in the cycle where an EOP beat of an open frame (or a single-beat SOP+EOP) is accepted, never on other beats, never while `in_ready` is low and never during reset. When it is low, `stat_word` and `stat_err` are zero.
- R2: `stat_word[31:16]` holds the frame length in bytes. This is 8 for every accepted beat of the frame, minus `in_empty` of the EOP beat. A stalled beat is counted once.
- R3: `stat_word[15:0]` holds the payload length. This is the frame length minus the header (14 bytes, 18 with one tag, 22 with two tags) and minus the 4 FCS bytes, and it is zero if the frame is shorter than that.
- R4: `stat_err[0]` is set when the frame length is below 64. `stat_err[1]` is set when it exceeds `MAX_FRAME_BYTES` (default 1518; exactly 1518 is not oversized).
- R5: `stat_err[2]` is set when the length/type value after any tags is below 0x0600 and differs from the payload length. Values of 0x0600 and above never set it.
- R6: A first type of 0x8100 followed by a non-0x8100 value sets `stat_word[33]`. A first type of 0x88A8, or 0x8100 twice, sets `stat_word[32]`. The two bits are never both set.
- R7: A final type of 0x8808 sets `stat_word[34]`. The 16-bit opcode after it additionally sets `stat_word[35]` for 0x0001 or `stat_word[39]` for 0x0101.
- R8: A destination of all ones sets `stat_word[36]`. Otherwise, bit 0 of the first destination byte being set sets `stat_word[37]`. Otherwise `stat_word[38]` is set. Exactly one of the three is set.
- R9: `stat_err[5]` is set when `in_err` was high on any accepted beat of the frame.
- R10: `stat_err[4]` is set when `in_valid` was low in any cycle after the SOP beat and before the EOP beat. `stat_err[3]` and `stat_err[6]` are always zero.
- R11: An EOP or data beat outside a frame produces no strobe. A new SOP inside a frame discards the length, header, client error and underflow gathered so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat valid on the watched stream |
| in_ready | input | 1 | Sink ready on the watched stream |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | 64 | Beat data, first byte in [63:56] |
| in_empty | input | 3 | Unused bytes on the EOP beat |
| in_err | input | 1 | Client error flag for the beat |
| stat_valid | output | 1 | Qualifies status word and error vector |
| stat_word | output | 40 | Lengths and frame-type flags |
| stat_err | output | 7 | Error flags |

## Verification
All state is private to one frame, so a wrong internal state shows up in the status of that frame. It appears at the latest on its EOP beat, and nothing is left behind after the close.

Each kind of fault has its own symptom:
- A stuck state register gives a missing or extra strobe, or a strobe on a stray EOP.
- A byte counter that is off or not cleared shows in both length fields.
- A header slot that keeps stale bytes turns up as wrong type flags on the next short frame.
- Sticky error flags that fail to clear on restart mark a clean frame as bad.

Each table frame is checked field by field at its closing beat. Directed cases cover a stall on the closing beat, a stray EOP and an abandoned frame.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int BEAT_W     = BEAT_BYTES * 8;
    localparam int EMPTY_W    = $clog2(BEAT_BYTES);
    localparam int LEN_W      = 16;
    localparam int STAT_W     = 40;
    localparam int ERR_W      = 7;
    localparam int HDR_SLOTS  = 3;
    localparam int HDR_BYTES  = HDR_SLOTS * BEAT_BYTES;
    localparam int DA_BYTES   = 6;
    localparam int TAG_FIRST  = 12;
    localparam int TAG_BYTES  = HDR_BYTES - TAG_FIRST;
    localparam int MIN_FRAME  = 64;
    localparam int BASE_HDR   = 14;
    localparam int TAG_LEN    = 4;
    localparam int FCS_BYTES  = 4;

    // status word fields
    localparam int SW_PAY_LSB = 0;
    localparam int SW_PKT_LSB = 16;
    localparam int SW_STACKED = 32;
    localparam int SW_VLAN    = 33;
    localparam int SW_CTRL    = 34;
    localparam int SW_PAUSE   = 35;
    localparam int SW_BCAST   = 36;
    localparam int SW_MCAST   = 37;
    localparam int SW_UCAST   = 38;
    localparam int SW_PFC     = 39;

    // error vector fields
    localparam int EV_SHORT   = 0;
    localparam int EV_LONG    = 1;
    localparam int EV_LENFLD  = 2;
    localparam int EV_STARVE  = 4;
    localparam int EV_CLIENT  = 5;

    localparam logic [15:0] TY_CTAG   = 16'h8100;
    localparam logic [15:0] TY_STAG   = 16'h88A8;
    localparam logic [15:0] TY_MACCTL = 16'h8808;
    localparam logic [15:0] OPC_PAUSE = 16'h0001;
    localparam logic [15:0] OPC_PFC   = 16'h0101;
    localparam logic [15:0] TY_FLOOR  = 16'h0600;

    typedef enum logic {S_IDLE, S_BODY} trk_state_e;

    function automatic logic [15:0] pick16(input logic [TAG_BYTES*8-1:0] area, input int at);
        return area[TAG_BYTES*8-1-8*at -: 16];
    endfunction
endpackage

// File: rtl/fsc_beat_tracker.sv
module fsc_beat_tracker
    import fsc_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_fire,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               in_err,
    output logic               frame_done,
    output logic               frame_start,
    output logic               slot_we,
    output logic [IDX_W-1:0]   slot_idx,
    output logic [LEN_W-1:0]   pkt_len,
    output logic               client_err,
    output logic               underflow
);
    localparam logic [LEN_W:0] SAT_TOP = {1'b0, {LEN_W{1'b1}}};

    trk_state_e state_q, state_d;
    logic [LEN_W-1:0] bytes_q;
    logic [IDX_W-1:0] idx_q;
    logic             cerr_q, uf_q;

    logic             take;
    logic [LEN_W-1:0] base;
    logic [IDX_W-1:0] cur_idx;
    logic [LEN_W:0]   sum_full, sum_last;
    logic             cerr_now, uf_now;

    function automatic logic [LEN_W-1:0] sat(input logic [LEN_W:0] v);
        return (v > SAT_TOP) ? {LEN_W{1'b1}} : v[LEN_W-1:0];
    endfunction

    assign take     = rst_n && beat_fire && (in_sop || state_q == S_BODY);
    assign base     = in_sop ? '0 : bytes_q;
    assign cur_idx  = in_sop ? '0 : idx_q;
    assign sum_full = {1'b0, base} + (LEN_W+1)'(BEAT_BYTES);
    assign sum_last = {1'b0, base} + (LEN_W+1)'(BEAT_BYTES) - (LEN_W+1)'(in_empty);
    assign cerr_now = (in_sop ? 1'b0 : cerr_q) | in_err;
    assign uf_now   = in_sop ? 1'b0 : uf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (take && in_sop && !in_eop) state_d = S_BODY;
            S_BODY: if (take && in_eop)            state_d = S_IDLE;
            default:                               state_d = S_IDLE;
        endcase
    end

    // per-frame accumulators
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q <= '0;
            idx_q   <= '0;
            cerr_q  <= 1'b0;
            uf_q    <= 1'b0;
        end else begin
            if (take && !in_eop) begin
                bytes_q <= sat(sum_full);
                idx_q   <= (cur_idx < IDX_W'(HDR_SLOTS)) ? cur_idx + 1'b1 : cur_idx;
                cerr_q  <= cerr_now;
                uf_q    <= uf_now;
            end
            if (state_q == S_BODY && !in_valid) uf_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        frame_done  = take && in_eop;
        frame_start = take && in_sop;
        slot_we     = take && (cur_idx < IDX_W'(HDR_SLOTS));
        slot_idx    = cur_idx;
        pkt_len     = sat(sum_last);
        client_err  = cerr_now;
        underflow   = uf_now;
    end

    p_close_on_eop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_eop) |=> (state_q == S_IDLE));
    p_open_on_sop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && in_sop && !in_eop) |=> (state_q == S_BODY));
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !(beat_fire && in_sop)) |=> (state_q == S_IDLE));
endmodule

// File: rtl/fsc_hdr_capture.sv
module fsc_hdr_capture
    import fsc_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic                   slot_we,
    input  logic [IDX_W-1:0]       slot_idx,
    input  logic [BEAT_W-1:0]      beat_data,
    output logic [DA_BYTES*8-1:0]  dst_addr,
    output logic [TAG_BYTES*8-1:0] tag_area
);
    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_byte
        localparam int SLOT = g / BEAT_BYTES;
        localparam int LANE = g % BEAT_BYTES;
        if (g < DA_BYTES || g >= TAG_FIRST) begin : g_keep
            logic [7:0] held_q;
            logic [7:0] live;
            logic       hit;
            assign hit  = slot_we && (slot_idx == IDX_W'(SLOT));
            assign live = hit ? beat_data[BEAT_W-1-8*LANE -: 8]
                        : (frame_start ? 8'h00 : held_q);
            always_ff @(posedge clk) begin
                if (!rst_n) held_q <= 8'h00;
                else        held_q <= live;
            end
            if (g < DA_BYTES) begin : g_da
                assign dst_addr[DA_BYTES*8-1-8*g -: 8] = live;
            end else begin : g_tag
                assign tag_area[TAG_BYTES*8-1-8*(g-TAG_FIRST) -: 8] = live;
            end
        end
    end
endmodule

// File: rtl/fsc_type_decode.sv
module fsc_type_decode
    import fsc_pkg::*;
(
    input  logic [DA_BYTES*8-1:0]  dst_addr,
    input  logic [TAG_BYTES*8-1:0] tag_area,
    input  logic [LEN_W-1:0]       pkt_len,
    output logic                   is_stacked,
    output logic                   is_vlan,
    output logic                   is_ctrl,
    output logic                   is_pause,
    output logic                   is_pfc,
    output logic                   is_bcast,
    output logic                   is_mcast,
    output logic                   is_ucast,
    output logic [LEN_W-1:0]       payload_len,
    output logic                   len_mismatch
);
    logic [15:0]      ty_a, ty_b, ty_fin, opc;
    logic [LEN_W-1:0] overhead;

    always_comb begin
        ty_a       = pick16(tag_area, 0);
        ty_b       = pick16(tag_area, 4);
        is_stacked = (ty_a == TY_STAG) || (ty_a == TY_CTAG && ty_b == TY_CTAG);
        is_vlan    = (ty_a == TY_CTAG) && !is_stacked;
        if (is_stacked) begin
            ty_fin   = pick16(tag_area, 8);
            opc      = pick16(tag_area, 10);
            overhead = LEN_W'(BASE_HDR + FCS_BYTES + 2*TAG_LEN);
        end else if (is_vlan) begin
            ty_fin   = ty_b;
            opc      = pick16(tag_area, 6);
            overhead = LEN_W'(BASE_HDR + FCS_BYTES + TAG_LEN);
        end else begin
            ty_fin   = ty_a;
            opc      = pick16(tag_area, 2);
            overhead = LEN_W'(BASE_HDR + FCS_BYTES);
        end
        is_ctrl      = (ty_fin == TY_MACCTL);
        is_pause     = is_ctrl && (opc == OPC_PAUSE);
        is_pfc       = is_ctrl && (opc == OPC_PFC);
        is_bcast     = &dst_addr;
        is_mcast     = !is_bcast && dst_addr[DA_BYTES*8-8];
        is_ucast     = !is_bcast && !is_mcast;
        payload_len  = (pkt_len > overhead) ? pkt_len - overhead : '0;
        len_mismatch = (ty_fin < TY_FLOOR) && (LEN_W'(ty_fin) != payload_len);
    end
endmodule

// File: rtl/frame_status_classifier.sv
module frame_status_classifier
    import fsc_pkg::*;
#(
    parameter int MAX_FRAME_BYTES = 1518
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_ready,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [BEAT_W-1:0]  in_data,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               in_err,
    output logic               stat_valid,
    output logic [STAT_W-1:0]  stat_word,
    output logic [ERR_W-1:0]   stat_err
);
    localparam int IDX_W = $clog2(HDR_SLOTS + 1);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_FRAME_BYTES);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_FRAME);

    logic                   beat_fire, frame_done, frame_start, slot_we;
    logic [IDX_W-1:0]       slot_idx;
    logic [LEN_W-1:0]       pkt_len, payload_len;
    logic                   client_err, underflow;
    logic [DA_BYTES*8-1:0]  dst_addr;
    logic [TAG_BYTES*8-1:0] tag_area;
    logic is_stacked, is_vlan, is_ctrl, is_pause, is_pfc;
    logic is_bcast, is_mcast, is_ucast, len_mismatch;

    assign beat_fire = in_valid && in_ready;

    fsc_beat_tracker #(.IDX_W(IDX_W)) u_track (
        .clk, .rst_n, .beat_fire, .in_valid, .in_sop, .in_eop, .in_empty, .in_err,
        .frame_done, .frame_start, .slot_we, .slot_idx, .pkt_len, .client_err, .underflow
    );

    fsc_hdr_capture #(.IDX_W(IDX_W)) u_hdr (
        .clk, .rst_n, .frame_start, .slot_we, .slot_idx,
        .beat_data(in_data), .dst_addr, .tag_area
    );

    fsc_type_decode u_dec (
        .dst_addr, .tag_area, .pkt_len,
        .is_stacked, .is_vlan, .is_ctrl, .is_pause, .is_pfc,
        .is_bcast, .is_mcast, .is_ucast, .payload_len, .len_mismatch
    );

    always_comb begin
        stat_valid = frame_done;
        stat_word  = '0;
        stat_err   = '0;
        if (frame_done) begin
            stat_word[SW_PAY_LSB +: 16] = payload_len;
            stat_word[SW_PKT_LSB +: 16] = pkt_len;
            stat_word[SW_STACKED]       = is_stacked;
            stat_word[SW_VLAN]          = is_vlan;
            stat_word[SW_CTRL]          = is_ctrl;
            stat_word[SW_PAUSE]         = is_pause;
            stat_word[SW_BCAST]         = is_bcast;
            stat_word[SW_MCAST]         = is_mcast;
            stat_word[SW_UCAST]         = is_ucast;
            stat_word[SW_PFC]           = is_pfc;
            stat_err[EV_SHORT]          = pkt_len < LEN_MIN;
            stat_err[EV_LONG]           = pkt_len > LEN_CAP;
            stat_err[EV_LENFLD]         = len_mismatch;
            stat_err[EV_STARVE]         = underflow;
            stat_err[EV_CLIENT]         = client_err;
        end
    end

    p_strobe_on_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (in_valid && in_ready && in_eop));
    p_quiet_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |-> (stat_word == '0 && stat_err == '0));
    p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> ($countones(stat_word[SW_UCAST:SW_BCAST]) == 1));
    p_tag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> !(stat_word[SW_STACKED] && stat_word[SW_VLAN]));
    p_opcode_in_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && (stat_word[SW_PAUSE] || stat_word[SW_PFC])) |-> stat_word[SW_CTRL]);
    p_pause_pfc_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $onehot0({stat_word[SW_PAUSE], stat_word[SW_PFC]}));
endmodule

// File: tb/frame_status_classifier_tb_top.sv
module frame_status_classifier_tb_top;
    localparam int CLK_NS = 10;
    localparam int Q      = CLK_NS / 4;
    localparam logic [47:0] SA = 48'h665544332211;
    localparam logic [47:0] UC = 48'h001122334455;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 0, in_ready = 1, in_sop = 0, in_eop = 0, in_err = 0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_empty = '0;
    logic        stat_valid;
    logic [39:0] stat_word;
    logic [6:0]  stat_err;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    frame_status_classifier dut_i (
        .clk, .rst_n, .in_valid, .in_ready, .in_sop, .in_eop, .in_data,
        .in_empty, .in_err, .stat_valid, .stat_word, .stat_err
    );

    typedef struct packed {
        logic [191:0] hdr;
        logic [15:0]  len;
        logic         cerr;
        logic         gap;
        logic [39:0]  ew;
        logic [6:0]   ee;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{{UC, SA, 16'h0800, 80'h0},                                      16'd64,   1'b0, 1'b0, 40'h40_0040_002E, 7'h00},
        '{{48'hFFFFFFFFFFFF, SA, 16'h0800, 80'h0},                        16'd60,   1'b0, 1'b0, 40'h10_003C_002A, 7'h01},
        '{{48'h01005E000001, SA, 16'h8100, 16'h0005, 16'h0800, 48'h0},    16'd100,  1'b0, 1'b0, 40'h22_0064_004E, 7'h00},
        '{{48'h020000000001, SA, 16'h88A8, 16'h0007, 16'h8100, 16'h0009, 16'h0800, 16'h0},
                                                                          16'd128,  1'b0, 1'b0, 40'h41_0080_0066, 7'h00},
        '{{48'h0180C2000001, SA, 16'h8808, 16'h0001, 64'h0},              16'd64,   1'b0, 1'b0, 40'h2C_0040_002E, 7'h00},
        '{{48'h0180C2000001, SA, 16'h8808, 16'h0101, 64'h0},              16'd64,   1'b0, 1'b0, 40'hA4_0040_002E, 7'h00},
        '{{UC, SA, 16'h002E, 80'h0},                                      16'd64,   1'b0, 1'b0, 40'h40_0040_002E, 7'h00},
        '{{UC, SA, 16'h0020, 80'h0},                                      16'd64,   1'b0, 1'b0, 40'h40_0040_002E, 7'h04},
        '{{UC, SA, 16'h0800, 80'h0},                                      16'd1519, 1'b0, 1'b0, 40'h40_05EF_05DD, 7'h02},
        '{{UC, SA, 16'h0800, 80'h0},                                      16'd1518, 1'b0, 1'b0, 40'h40_05EE_05DC, 7'h00},
        '{{UC, SA, 16'h0800, 80'h0},                                      16'd64,   1'b1, 1'b0, 40'h40_0040_002E, 7'h20},
        '{{UC, SA, 16'h0800, 80'h0},                                      16'd64,   1'b0, 1'b1, 40'h40_0040_002E, 7'h10},
        '{{48'h0180C2000001, SA, 16'h8808, 16'h0002, 64'h0},              16'd64,   1'b0, 1'b0, 40'h24_0040_002E, 7'h00},
        '{{UC, SA, 16'h0800, 80'h0},                                      16'd8,    1'b0, 1'b0, 40'h40_0008_0000, 7'h01}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [191:0] hdr, input int len, input int idx);
        if (idx >= len) return 8'h00;
        if (idx < 24)   return hdr[191-8*idx -: 8];
        return idx[7:0];
    endfunction

    task automatic idle_bus();
        in_valid = 0; in_sop = 0; in_eop = 0; in_err = 0; in_data = '0; in_empty = '0;
    endtask

    task automatic drive_beat(input logic [191:0] hdr, input int len, input int b, input int beats);
        in_valid = 1;
        in_sop   = (b == 0);
        in_eop   = (b == beats - 1);
        for (int k = 0; k < 8; k++) in_data[63-8*k -: 8] = fbyte(hdr, len, b*8 + k);
        in_empty = (b == beats - 1) ? 3'(beats*8 - len) : 3'd0;
    endtask

    task automatic send_frame(input vec_t v);
        int beats;
        bit early, seen;
        logic [39:0] w;
        logic [6:0]  e;
        beats = (int'(v.len) + 7) / 8;
        early = 0; seen = 0; w = '0; e = '0;
        for (int b = 0; b < beats; b++) begin
            if (v.gap && b == 2) begin
                @(negedge clk); idle_bus();
                #Q; if (stat_valid) early = 1;
            end
            @(negedge clk);
            drive_beat(v.hdr, int'(v.len), b, beats);
            in_err = v.cerr && (b == 1);
            #Q;
            if (b == beats - 1) begin
                seen = stat_valid; w = stat_word; e = stat_err;
            end else if (stat_valid) early = 1;
        end
        @(negedge clk); idle_bus();
        chk(seen,   "R1", "strobe on EOP beat", 64'(seen), 64'd1);
        chk(!early, "R1", "no strobe before EOP", 64'(early), 64'd0);
        chk(w[31:16] == v.ew[31:16], "R2", "packet length", 64'(w[31:16]), 64'(v.ew[31:16]));
        chk(w[15:0] == v.ew[15:0], "R3", "payload length", 64'(w[15:0]), 64'(v.ew[15:0]));
        chk(w[39:32] == v.ew[39:32], "R6/R7/R8", "type flags", 64'(w[39:32]), 64'(v.ew[39:32]));
        chk(e[1:0] == v.ee[1:0], "R4", "size errors", 64'(e[1:0]), 64'(v.ee[1:0]));
        chk(e[2] == v.ee[2], "R5", "length field error", 64'(e[2]), 64'(v.ee[2]));
        chk({e[6], e[4], e[3]} == {v.ee[6], v.ee[4], v.ee[3]}, "R10", "underflow and unused",
            64'({e[6], e[4], e[3]}), 64'({v.ee[6], v.ee[4], v.ee[3]}));
        chk(e[5] == v.ee[5], "R9", "client error", 64'(e[5]), 64'(v.ee[5]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset: a single-beat frame offered during reset must not strobe (R1)
        repeat (2) @(negedge clk);
        drive_beat(VECS[13].hdr, 8, 0, 1);
        #Q;
        chk(!stat_valid && stat_word == '0 && stat_err == '0, "R1", "quiet during reset",
            64'(stat_valid), 64'd0);
        @(negedge clk); idle_bus();
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) send_frame(VECS[i]);

        // stall on EOP beat: no strobe while ready low, one strobe after (R1, R2)
        @(negedge clk); drive_beat(VECS[0].hdr, 16, 0, 2);
        @(negedge clk); drive_beat(VECS[0].hdr, 16, 1, 2); in_ready = 0;
        #Q; chk(!stat_valid, "R1", "no strobe while stalled", 64'(stat_valid), 64'd0);
        @(negedge clk); in_ready = 1;
        #Q; chk(stat_valid, "R1", "strobe after stall", 64'(stat_valid), 64'd1);
        chk(stat_word[31:16] == 16'd16, "R2", "stalled beat counted once", 64'(stat_word[31:16]), 64'd16);
        chk(stat_err == 7'h01, "R4", "short stalled frame", 64'(stat_err), 64'h01);
        @(negedge clk); idle_bus();

        // stray EOP outside a frame (R11)
        @(negedge clk); in_valid = 1; in_eop = 1; in_data = 64'hFFFF_FFFF_FFFF_FFFF;
        #Q; chk(!stat_valid, "R11", "stray EOP ignored", 64'(stat_valid), 64'd0);
        @(negedge clk); idle_bus();
        send_frame(VECS[0]);

        // abandoned frame with client error and a gap, then restart (R11)
        @(negedge clk); drive_beat(VECS[1].hdr, 64, 0, 8); in_err = 1;
        @(negedge clk); drive_beat(VECS[1].hdr, 64, 1, 8); in_err = 1;
        @(negedge clk); idle_bus();
        send_frame(VECS[0]);
        chk(1'b1, "R11", "restart covered by preceding frame checks", 64'd1, 64'd1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule